// File: doc/BRIEF.md
# Stack-Relative Local Register File

This block holds the local registers of a processor core. The register number in an instruction is a local number. It is added to a movable base pointer, and the sum is taken modulo the file size to give the physical register. Loading a new base moves the whole window of visible registers. A context switch is therefore a single base load, and no register contents are copied. The file has one write port and two read ports. Read results are registered, and a write followed by a read of the same physical register in the same cycle returns the new data.

The physical file is split into groups of 16 consecutive registers. Each group has one bit in a protect mask. A user-mode access that lands in a protected group is suppressed, and the block raises a one-cycle fault pulse that carries the group number. Only supervisor mode may change the base, the protect mask or the stack-cache limit.

The block also tracks the part of the file that the runtime stack cache occupies. An allocation moves the base down and grows the live region. A deallocation moves the base up and shrinks the live region. When an allocation would push the live region past the programmed limit, the block requests a spill trap. When a deallocation goes below the bottom of the live region, it requests a fill trap. The live count is always available, so that software saves only the registers in use.

Top module: `stkreg_file`

## Requirements
- R1: After synchronous reset the base is 0, the live count is 0, the protect mask is all clear, the limit is 128, and both read data outputs, `prot_fault`, `spill_req`, `fill_req` and `trap_cnt` are 0.
- R2: The physical index is (base + local number) mod 128. Read data appears on the clock edge after the request. A read port whose enable is low holds its last value.
- R3: When the write port and a read port address the same physical register in one cycle, the read returns the data being written.
- R4: A supervisor base load changes the base on the next edge and empties the live region (live count 0). Register contents stay where they are. A stack operation in the same cycle is ignored.
- R5: A user-mode access to a physical register whose group (index bits [6:4]) has its protect bit set is suppressed: a write changes nothing, and a read returns 0. `prot_fault` pulses for one cycle with `fault_group` set to that group. If several accesses fault together, the group reported is the write's first, then read port A's, then read port B's. Supervisor accesses never fault.
- R6: In user mode, base, protect-mask and limit loads are ignored. Each such attempt raises `prot_fault` with `fault_group` 0, unless a faulting access in the same cycle supplies the group.
- R7: A supervisor limit load sets the cache limit to the requested value clamped to [32,128]. A stack operation in the same cycle is ignored.
- R8: `stk_op` = 1 allocates `stk_amt` registers, and the base decreases by `stk_amt`. If live + amt exceeds the limit, `spill_req` pulses, `trap_cnt` = live + amt − limit, and live becomes the limit. Otherwise live grows by amt. Reaching the limit exactly does not spill.
- R9: `stk_op` = 2 frees `stk_amt` registers, and the base increases by `stk_amt`. If amt exceeds live, `fill_req` pulses, `trap_cnt` = amt − live, and live becomes 0. Otherwise live shrinks by amt. `stk_op` values 0 and 3 do nothing.
- R10: `live_cnt` always shows the current live count (0 to 128). It is registered and is updated on the edge that applies each stack operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| wr_en | input | 1 | Write port enable |
| wr_num | input | 7 | Write local number |
| wr_data | input | 32 | Write data |
| rda_en | input | 1 | Read port A enable |
| rda_num | input | 7 | Read port A local number |
| rdb_en | input | 1 | Read port B enable |
| rdb_num | input | 7 | Read port B local number |
| rda_data | output | 32 | Read port A data, registered |
| rdb_data | output | 32 | Read port B data, registered |
| base_ld | input | 1 | Load a new base (context switch) |
| base_val | input | 7 | New base value |
| pmask_ld | input | 1 | Load the protect mask |
| pmask_val | input | 8 | Protect mask, bit g guards group g |
| limit_ld | input | 1 | Load the cache limit |
| limit_val | input | 8 | Requested limit (clamped) |
| stk_op | input | 2 | 0 none, 1 allocate, 2 free, 3 none |
| stk_amt | input | 8 | Register count for the stack operation |
| live_cnt | output | 8 | Current live register count |
| spill_req | output | 1 | One-cycle spill trap request |
| fill_req | output | 1 | One-cycle fill trap request |
| trap_cnt | output | 8 | Registers to spill or fill, 0 when no trap |
| prot_fault | output | 1 | One-cycle protection fault pulse |
| fault_group | output | 3 | Group number of the fault |

## Verification
The hardest cases combine several behaviours in one cycle. One is a protected group reached only because the base wrapped past the top of the file. Another is faulting accesses on all ports at once, which exercises the priority of the reported group. To reach them, the stimulus first writes a known pattern to every register. It then moves the base near the top so that small local numbers wrap to low groups, sets selected protect bits, and issues user writes and reads together. The spill limit is first lowered to its clamped minimum, so the stack boundary cases (exactly at the limit, one past it, a free larger than the live count) need only a few allocations.

// File: rtl/stkreg_pkg.sv
package stkreg_pkg;

  typedef enum logic [1:0] {
    STK_NONE  = 2'd0,
    STK_ALLOC = 2'd1,
    STK_FREE  = 2'd2,
    STK_NOP3  = 2'd3
  } stk_op_e;

  function automatic int unsigned clamp_range(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/stkreg_mem.sv
module stkreg_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  parameter int NRP   = 2,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IW-1:0]            widx,
  input  logic [DW-1:0]            wdata,
  input  logic [NRP-1:0]           re,
  input  logic [NRP-1:0]           rok,
  input  logic [NRP-1:0][IW-1:0]   ridx,
  output logic [NRP-1:0][DW-1:0]   rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[p] <= '0;
      end else if (re[p]) begin
        if (!rok[p])
          rdata[p] <= '0;
        else if (we && (widx == ridx[p]))
          rdata[p] <= wdata;
        else
          rdata[p] <= store[ridx[p]];
      end
    end

    AST_BYPASS_NEW: assert property (@(posedge clk) disable iff (rst)
      (re[p] && rok[p] && we && widx == ridx[p]) |=> rdata[p] == $past(wdata)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !re[p] |=> $stable(rdata[p])); // R2
    AST_SUPPRESS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (re[p] && !rok[p]) |=> rdata[p] == '0); // R5
  end

endmodule

// File: rtl/stkreg_guard.sv
module stkreg_guard #(
  parameter int NGRP = 8,
  localparam int GW  = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            user_mode,
  input  logic [NGRP-1:0] pmask,
  input  logic            we,
  input  logic [GW-1:0]   wgrp,
  input  logic            rae,
  input  logic [GW-1:0]   agrp,
  input  logic            rbe,
  input  logic [GW-1:0]   bgrp,
  input  logic            ctl_try,
  output logic            w_ok,
  output logic            a_ok,
  output logic            b_ok,
  output logic            fault_q,
  output logic [GW-1:0]   group_q
);

  logic w_bad, a_bad, b_bad, c_bad;

  always_comb begin
    w_ok  = !(user_mode && pmask[wgrp]);
    a_ok  = !(user_mode && pmask[agrp]);
    b_ok  = !(user_mode && pmask[bgrp]);
    w_bad = we  && !w_ok;
    a_bad = rae && !a_ok;
    b_bad = rbe && !b_ok;
    c_bad = user_mode && ctl_try;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      group_q <= '0;
    end else begin
      fault_q <= w_bad | a_bad | b_bad | c_bad;
      if (w_bad)      group_q <= wgrp;
      else if (a_bad) group_q <= agrp;
      else if (b_bad) group_q <= bgrp;
      else            group_q <= '0;
    end
  end

  AST_CTL_FAULT: assert property (@(posedge clk) disable iff (rst)
    (user_mode && ctl_try) |=> fault_q); // R6
  AST_SUPER_QUIET: assert property (@(posedge clk) disable iff (rst)
    !user_mode |=> !fault_q); // R5
  AST_WRITE_GROUP: assert property (@(posedge clk) disable iff (rst)
    (we && user_mode && pmask[wgrp]) |=> (fault_q && group_q == $past(wgrp))); // R5

endmodule

// File: rtl/stkreg_ctrl.sv
module stkreg_ctrl
  import stkreg_pkg::*;
#(
  parameter int NREGS     = 128,
  parameter int NGRP      = 8,
  parameter int MIN_CACHE = 32,
  localparam int IW       = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            user_mode,
  input  logic            base_ld,
  input  logic [IW-1:0]   base_val,
  input  logic            pmask_ld,
  input  logic [NGRP-1:0] pmask_val,
  input  logic            limit_ld,
  input  logic [IW:0]     limit_val,
  input  logic [1:0]      stk_op,
  input  logic [IW:0]     stk_amt,
  output logic [IW-1:0]   base_q,
  output logic [NGRP-1:0] pmask_q,
  output logic [IW:0]     live_q,
  output logic            spill_q,
  output logic            fill_q,
  output logic [IW:0]     cnt_q
);

  localparam logic [IW:0] LIM_RST = (IW+1)'(NREGS);

  logic [IW:0]   lim_q;
  logic [IW:0]   lim_new;
  logic [IW+1:0] grow;
  logic [IW:0]   excess;
  logic [IW:0]   deficit;
  logic          over;
  logic          under;
  logic          sup;
  stk_op_e       op;

  always_comb begin
    sup     = !user_mode;
    op      = stk_op_e'(stk_op);
    lim_new = (IW+1)'(clamp_range(int'(limit_val), MIN_CACHE, NREGS));
    grow    = {1'b0, live_q} + {1'b0, stk_amt};
    over    = grow > {1'b0, lim_q};
    excess  = grow[IW:0] - lim_q;
    under   = stk_amt > live_q;
    deficit = stk_amt - live_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      pmask_q <= '0;
      live_q  <= '0;
      lim_q   <= LIM_RST;
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      spill_q <= 1'b0;
      fill_q  <= 1'b0;
      cnt_q   <= '0;
      if (sup && pmask_ld) pmask_q <= pmask_val;
      if (sup && base_ld) begin
        base_q <= base_val;
        live_q <= '0;
      end else if (sup && limit_ld) begin
        lim_q <= lim_new;
      end else begin
        case (op)
          STK_ALLOC: begin
            base_q <= base_q - stk_amt[IW-1:0];
            if (over) begin
              spill_q <= 1'b1;
              cnt_q   <= excess;
              live_q  <= lim_q;
            end else begin
              live_q <= grow[IW:0];
            end
          end
          STK_FREE: begin
            base_q <= base_q + stk_amt[IW-1:0];
            if (under) begin
              fill_q <= 1'b1;
              cnt_q  <= deficit;
              live_q <= '0;
            end else begin
              live_q <= live_q - stk_amt;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (base_q == '0 && live_q == '0 && pmask_q == '0 && lim_q == LIM_RST)); // R1
  AST_SPILL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    spill_q |-> live_q == lim_q); // R8
  AST_FILL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fill_q |-> live_q == '0); // R9
  AST_LIVE_BOUND: assert property (@(posedge clk) disable iff (rst)
    live_q <= LIM_RST); // R10
  AST_USER_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (user_mode && base_ld && stk_op == 2'd0) |=> $stable(base_q)); // R6
  AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(spill_q && fill_q)); // R9
  AST_SWITCH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!user_mode && base_ld) |=> live_q == '0); // R4

endmodule

// File: rtl/stkreg_file.sv
module stkreg_file #(
  parameter int NREGS     = 128,
  parameter int DW        = 32,
  parameter int GROUP     = 16,
  parameter int MIN_CACHE = 32,
  localparam int IW       = $clog2(NREGS),
  localparam int NGRP     = NREGS / GROUP,
  localparam int GW       = $clog2(NGRP)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            user_mode,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_num,
  input  logic [DW-1:0]   wr_data,
  input  logic            rda_en,
  input  logic [IW-1:0]   rda_num,
  input  logic            rdb_en,
  input  logic [IW-1:0]   rdb_num,
  output logic [DW-1:0]   rda_data,
  output logic [DW-1:0]   rdb_data,
  input  logic            base_ld,
  input  logic [IW-1:0]   base_val,
  input  logic            pmask_ld,
  input  logic [NGRP-1:0] pmask_val,
  input  logic            limit_ld,
  input  logic [IW:0]     limit_val,
  input  logic [1:0]      stk_op,
  input  logic [IW:0]     stk_amt,
  output logic [IW:0]     live_cnt,
  output logic            spill_req,
  output logic            fill_req,
  output logic [IW:0]     trap_cnt,
  output logic            prot_fault,
  output logic [GW-1:0]   fault_group
);

  logic [IW-1:0]         base_q;
  logic [NGRP-1:0]       pmask_q;
  logic [IW-1:0]         widx;
  logic [1:0][IW-1:0]    ridx;
  logic [1:0]            ren;
  logic [1:0]            rok;
  logic [1:0][DW-1:0]    rdat;
  logic                  w_ok;
  logic                  ctl_try;

  always_comb begin
    widx    = base_q + wr_num;
    ridx[0] = base_q + rda_num;
    ridx[1] = base_q + rdb_num;
    ren     = {rdb_en, rda_en};
    ctl_try = base_ld | pmask_ld | limit_ld;
  end

  stkreg_ctrl #(
    .NREGS(NREGS), .NGRP(NGRP), .MIN_CACHE(MIN_CACHE)
  ) i_ctrl (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .base_ld(base_ld), .base_val(base_val),
    .pmask_ld(pmask_ld), .pmask_val(pmask_val),
    .limit_ld(limit_ld), .limit_val(limit_val),
    .stk_op(stk_op), .stk_amt(stk_amt),
    .base_q(base_q), .pmask_q(pmask_q), .live_q(live_cnt),
    .spill_q(spill_req), .fill_q(fill_req), .cnt_q(trap_cnt)
  );

  stkreg_guard #(.NGRP(NGRP)) i_guard (
    .clk(clk), .rst(rst), .user_mode(user_mode), .pmask(pmask_q),
    .we(wr_en),    .wgrp(widx[IW-1 -: GW]),
    .rae(rda_en),  .agrp(ridx[0][IW-1 -: GW]),
    .rbe(rdb_en),  .bgrp(ridx[1][IW-1 -: GW]),
    .ctl_try(ctl_try),
    .w_ok(w_ok), .a_ok(rok[0]), .b_ok(rok[1]),
    .fault_q(prot_fault), .group_q(fault_group)
  );

  stkreg_mem #(.DEPTH(NREGS), .DW(DW), .NRP(2)) i_mem (
    .clk(clk), .rst(rst),
    .we(wr_en && w_ok), .widx(widx), .wdata(wr_data),
    .re(ren), .rok(rok), .ridx(ridx), .rdata(rdat)
  );

  assign rda_data = rdat[0];
  assign rdb_data = rdat[1];

endmodule

// File: tb/test_stkreg_file.sv
module test_stkreg_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        user_mode = 0, wr_en = 0, rda_en = 0, rdb_en = 0;
  logic [6:0]  wr_num = 0, rda_num = 0, rdb_num = 0, base_val = 0;
  logic [31:0] wr_data = 0;
  logic        base_ld = 0, pmask_ld = 0, limit_ld = 0;
  logic [7:0]  pmask_val = 0, limit_val = 0, stk_amt = 0;
  logic [1:0]  stk_op = 0;
  logic [31:0] rda_data, rdb_data;
  logic [7:0]  live_cnt, trap_cnt;
  logic        spill_req, fill_req, prot_fault;
  logic [2:0]  fault_group;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  stkreg_file i_stkreg_file (
    .clk(clk), .rst(rst), .user_mode(user_mode),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .rda_en(rda_en), .rda_num(rda_num), .rdb_en(rdb_en), .rdb_num(rdb_num),
    .rda_data(rda_data), .rdb_data(rdb_data),
    .base_ld(base_ld), .base_val(base_val),
    .pmask_ld(pmask_ld), .pmask_val(pmask_val),
    .limit_ld(limit_ld), .limit_val(limit_val),
    .stk_op(stk_op), .stk_amt(stk_amt),
    .live_cnt(live_cnt), .spill_req(spill_req), .fill_req(fill_req),
    .trap_cnt(trap_cnt), .prot_fault(prot_fault), .fault_group(fault_group)
  );

  typedef struct packed {
    logic        user;
    logic        we;  logic [6:0] wn; logic [31:0] wd;
    logic        ae;  logic [6:0] an;
    logic        be;  logic [6:0] bn;
    logic        bl;  logic [6:0] bv;
    logic        pl;  logic [7:0] pv;
    logic        ll;  logic [7:0] lv;
    logic [1:0]  op;  logic [7:0] amt;
  } stim_t;

  typedef struct packed {
    logic [31:0] a, b;
    logic        fault; logic [2:0] grp;
    logic        spill, fill;
    logic [7:0]  cnt, live;
  } exp_t;

  exp_t  q_exp[$];
  string q_req[$];

  // independent reference state
  logic [31:0] m_mem [128];
  logic [6:0]  m_sp = 0;
  logic [7:0]  m_live = 0, m_lim = 128, m_pm = 0;
  logic [31:0] m_a = 0, m_b = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic stim_t idle();
    stim_t s;
    s = '0;
    return s;
  endfunction

  task automatic drive(stim_t s, string req);
    exp_t e;
    logic [6:0] pw, pa, pb;
    logic [2:0] wg, ag, bg;
    logic wf, af, bf, cf, blk;
    logic [8:0] need;
    @(negedge clk);
    user_mode = s.user; wr_en = s.we; wr_num = s.wn; wr_data = s.wd;
    rda_en = s.ae; rda_num = s.an; rdb_en = s.be; rdb_num = s.bn;
    base_ld = s.bl; base_val = s.bv; pmask_ld = s.pl; pmask_val = s.pv;
    limit_ld = s.ll; limit_val = s.lv; stk_op = s.op; stk_amt = s.amt;
    pw = m_sp + s.wn; pa = m_sp + s.an; pb = m_sp + s.bn;
    wg = pw[6:4]; ag = pa[6:4]; bg = pb[6:4];
    wf = s.we && s.user && m_pm[wg];
    af = s.ae && s.user && m_pm[ag];
    bf = s.be && s.user && m_pm[bg];
    cf = s.user && (s.bl || s.pl || s.ll);
    e = '0;
    e.fault = wf | af | bf | cf;
    e.grp = wf ? wg : af ? ag : bf ? bg : 3'd0;
    if (s.ae) m_a = af ? 32'd0 : (s.we && !wf && pw == pa) ? s.wd : m_mem[pa];
    if (s.be) m_b = bf ? 32'd0 : (s.we && !wf && pw == pb) ? s.wd : m_mem[pb];
    if (s.we && !wf) m_mem[pw] = s.wd;
    blk = 0;
    if (!s.user && s.pl) m_pm = s.pv;
    if (!s.user && s.bl) begin m_sp = s.bv; m_live = 0; blk = 1; end
    else if (!s.user && s.ll) begin
      m_lim = (s.lv < 32) ? 8'd32 : (s.lv > 128) ? 8'd128 : s.lv;
      blk = 1;
    end
    if (!blk && s.op == 2'd1) begin
      m_sp = m_sp - s.amt[6:0];
      need = m_live + s.amt;
      if (need > {1'b0, m_lim}) begin
        e.spill = 1; e.cnt = 8'(need - m_lim); m_live = m_lim;
      end else m_live = need[7:0];
    end else if (!blk && s.op == 2'd2) begin
      m_sp = m_sp + s.amt[6:0];
      if (s.amt > m_live) begin
        e.fill = 1; e.cnt = s.amt - m_live; m_live = 0;
      end else m_live = m_live - s.amt;
    end
    e.a = m_a; e.b = m_b; e.live = m_live;
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  // monitor: compares each result in the cycle after its stimulus edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        exp_t e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        chk(r, "rda_data", rda_data, e.a);
        chk(r, "rdb_data", rdb_data, e.b);
        chk(r, "prot_fault", 32'(prot_fault), 32'(e.fault));
        if (e.fault) chk(r, "fault_group", 32'(fault_group), 32'(e.grp));
        chk(r, "spill_req", 32'(spill_req), 32'(e.spill));
        chk(r, "fill_req", 32'(fill_req), 32'(e.fill));
        chk(r, "trap_cnt", 32'(trap_cnt), 32'(e.cnt));
        chk(r, "live_cnt", 32'(live_cnt), 32'(e.live));
      end
    end
  end

  task automatic wr(logic u, logic [6:0] n, logic [31:0] d, string req);
    stim_t s = idle(); s.user = u; s.we = 1; s.wn = n; s.wd = d; drive(s, req);
  endtask
  task automatic rd(logic u, logic [6:0] a, logic [6:0] b, string req);
    stim_t s = idle(); s.user = u; s.ae = 1; s.an = a; s.be = 1; s.bn = b; drive(s, req);
  endtask
  task automatic setbase(logic u, logic [6:0] v, string req);
    stim_t s = idle(); s.user = u; s.bl = 1; s.bv = v; drive(s, req);
  endtask
  task automatic setpm(logic u, logic [7:0] v, string req);
    stim_t s = idle(); s.user = u; s.pl = 1; s.pv = v; drive(s, req);
  endtask
  task automatic setlim(logic u, logic [7:0] v, string req);
    stim_t s = idle(); s.user = u; s.ll = 1; s.lv = v; drive(s, req);
  endtask
  task automatic stk(logic u, logic [1:0] op, logic [7:0] amt, string req);
    stim_t s = idle(); s.user = u; s.op = op; s.amt = amt; drive(s, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    stim_t s;
    for (int i = 0; i < 128; i++) m_mem[i] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen directly at the ports
    chk("R1", "live_cnt", 32'(live_cnt), 0);
    chk("R1", "rda_data", rda_data, 0);
    chk("R1", "rdb_data", rdb_data, 0);
    chk("R1", "prot_fault", 32'(prot_fault), 0);
    chk("R1", "spill_req", 32'(spill_req), 0);
    chk("R1", "fill_req", 32'(fill_req), 0);
    chk("R1", "trap_cnt", 32'(trap_cnt), 0);

    for (int i = 0; i < 128; i++) wr(0, 7'(i), 32'hA500_0000 | 32'(i), "R2");
    rd(0, 5, 127, "R2");
    s = idle(); s.ae = 1; s.an = 9; drive(s, "R2");       // port B holds
    setbase(0, 120, "R4");
    rd(0, 10, 0, "R4");                                   // wraps to phys 2
    s = idle(); s.we = 1; s.wn = 3; s.wd = 32'hDEAD_BEEF;
    s.ae = 1; s.an = 3; s.be = 1; s.bn = 4; drive(s, "R3");
    rd(0, 3, 3, "R3");

    setbase(0, 0, "R4");
    setpm(0, 8'h04, "R5");
    wr(1, 40, 32'h1111_1111, "R5");
    rd(0, 40, 41, "R5");
    rd(1, 33, 1, "R5");
    setpm(0, 8'h24, "R5");
    s = idle(); s.user = 1; s.we = 1; s.wn = 80; s.wd = 32'h2222_2222;
    s.ae = 1; s.an = 33; s.be = 1; s.bn = 34; drive(s, "R5"); // write group wins
    s = idle(); s.user = 1; s.ae = 1; s.an = 1; s.be = 1; s.bn = 35;
    drive(s, "R5");                                       // only B faults
    rd(0, 80, 0, "R5");
    setbase(0, 120, "R5");
    rd(1, 50, 0, "R5");                                   // wraps into group 2

    setbase(1, 64, "R6");
    rd(0, 8, 0, "R6");
    setpm(1, 8'h00, "R6");
    rd(1, 50, 0, "R6");
    setlim(1, 8'd32, "R6");

    setbase(0, 0, "R7");
    stk(1, 2'd1, 100, "R7");                              // limit still 128
    stk(1, 2'd2, 100, "R7");
    setlim(0, 8'd10, "R7");
    stk(1, 2'd1, 33, "R7");                               // spill 1 at limit 32
    setbase(0, 0, "R7");
    setlim(0, 8'd200, "R7");
    stk(1, 2'd1, 128, "R7");
    stk(1, 2'd1, 1, "R7");
    setbase(0, 0, "R4");
    s = idle(); s.ll = 1; s.lv = 8'd32; s.op = 2'd1; s.amt = 5;
    drive(s, "R7");                                       // op blocked

    stk(1, 2'd1, 20, "R8");
    rd(1, 0, 20, "R8");
    stk(1, 2'd1, 12, "R8");                               // exactly the limit
    stk(1, 2'd1, 4, "R8");                                // spill 4
    stk(1, 2'd0, 0, "R10");
    stk(1, 2'd3, 9, "R9");
    stk(1, 2'd2, 10, "R9");
    stk(1, 2'd2, 30, "R9");                               // fill 8
    stk(1, 2'd2, 0, "R10");

    s = idle(); s.bl = 1; s.bv = 5; s.op = 2'd1; s.amt = 3;
    drive(s, "R4");
    rd(0, 0, 123, "R4");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule